// File: doc/BRIEF.md
# Block-Synchronous Condition and Branch Unit

This unit resolves control flow for a wide issue machine that starts a whole execution block of up to eight instruction slots at once. For each block presented on the input side, it evaluates every conditional branch against the condition codes held when the block was issued. It then picks a single next program counter for the block and folds any condition-code updates from the block's slots into the architectural flags. The arithmetic results are computed elsewhere. Only their four result flags arrive here, one nibble per slot.

Because the whole block is handled together, the slot that holds a branch has no bearing on the outcome. A flag update written by one slot is visible only to blocks issued afterwards. The block's result is registered and appears one clock after it is presented. The updated flags are visible on `cc_o` in that same cycle, ready for the next block.

Top module: `block_branch_unit`

## Requirements
- R1: After reset, `cc_o` is 0, and `res_valid_o`, `taken_o`, `multi_taken_o` and `next_pc_o` are all 0.
- R2: A block presented with `blk_valid_i` high in one cycle produces `res_valid_o` high for exactly the next cycle. Without a block, `res_valid_o`, `taken_o` and `multi_taken_o` are 0.
- R3: A slot is a branch when its 2-bit class is 3. The class values are 0 ALU, 1 load, 2 store, 3 branch. Flags are packed as N bit 3, Z bit 2, V bit 1, C bit 0. The 4-bit condition selector is decoded as follows: 0 always, 1 Z, 2 !Z, 3 N!=V, 4 N==V, 5 !Z and N==V, 6 Z or N!=V, 7 C, 8 !C, and 9 to 15 never.
- R4: Branch conditions use the value `cc_o` held before the block. A flag update from a slot in the same block does not affect that block's branches.
- R5: The new flags come from the highest-numbered active ALU slot whose set-condition bit is 1. If there is no such slot, the flags are unchanged. The new value is visible on `cc_o` in the cycle `res_valid_o` is high.
- R6: A load, store or branch slot never changes the flags, even when its set-condition bit is 1.
- R7: When exactly one branch is taken, `next_pc_o` is that slot's target and `taken_o` is 1, whatever the slot position.
- R8: When two or more branches are taken, `multi_taken_o` is 1 and `next_pc_o` is the target of the lowest-numbered taken slot. Mutually exclusive branches, where only one is taken, leave `multi_taken_o` at 0.
- R9: When no branch is taken, `taken_o` is 0 and `next_pc_o` equals `blk_pc_i + 4*blk_len_i`.
- R10: Slots numbered `blk_len_i` and above are ignored. They neither branch nor update the flags.
- R11: In cycles with no block, `cc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_valid_i | input | 1 | A block is presented this cycle |
| blk_pc_i | input | PC_W | Address of the block's first word |
| blk_len_i | input | LEN_W | Number of active slots, 0 to SLOTS |
| slot_class_i | input | 2*SLOTS | Per-slot operation class |
| slot_setcc_i | input | SLOTS | Per-slot set-condition bit |
| slot_cond_i | input | 4*SLOTS | Per-slot branch condition selector |
| slot_target_i | input | PC_W*SLOTS | Per-slot branch target |
| slot_flags_i | input | 4*SLOTS | Per-slot result flags NZVC |
| res_valid_o | output | 1 | Block result valid |
| next_pc_o | output | PC_W | Resolved next address of the block |
| taken_o | output | 1 | A branch was taken |
| multi_taken_o | output | 1 | More than one branch was taken |
| cc_o | output | 4 | Architectural condition codes NZVC |

## Verification
A corrupted flag register shows up in two places one cycle after the block that caused it: directly on `cc_o`, and on `taken_o` and `next_pc_o` for the next block that branches. The sweep therefore loads every flag value through a setter block and then tests every selector against it. In the same branch block, a conflicting setter exposes any leak of the current block's updates into its own branches. A fault in the slot merge or the pick order appears on the very next result, as a wrong flag nibble or a wrong target.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

  localparam logic [1:0] CLS_ALU    = 2'd0;
  localparam logic [1:0] CLS_LOAD   = 2'd1;
  localparam logic [1:0] CLS_STORE  = 2'd2;
  localparam logic [1:0] CLS_BRANCH = 2'd3;

  localparam int CC_W = 4;
  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;

  localparam logic [3:0] SEL_AL = 4'd0;
  localparam logic [3:0] SEL_EQ = 4'd1;
  localparam logic [3:0] SEL_NE = 4'd2;
  localparam logic [3:0] SEL_LT = 4'd3;
  localparam logic [3:0] SEL_GE = 4'd4;
  localparam logic [3:0] SEL_GT = 4'd5;
  localparam logic [3:0] SEL_LE = 4'd6;
  localparam logic [3:0] SEL_CS = 4'd7;
  localparam logic [3:0] SEL_CC = 4'd8;

  function automatic logic cond_holds(input logic [3:0] sel, input logic [CC_W-1:0] cc);
    logic lt;
    lt = cc[CC_N] ^ cc[CC_V];
    case (sel)
      SEL_AL:  cond_holds = 1'b1;
      SEL_EQ:  cond_holds = cc[CC_Z];
      SEL_NE:  cond_holds = ~cc[CC_Z];
      SEL_LT:  cond_holds = lt;
      SEL_GE:  cond_holds = ~lt;
      SEL_GT:  cond_holds = ~cc[CC_Z] & ~lt;
      SEL_LE:  cond_holds = cc[CC_Z] | lt;
      SEL_CS:  cond_holds = cc[CC_C];
      SEL_CC:  cond_holds = ~cc[CC_C];
      default: cond_holds = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bbu_cond_eval.sv
module bbu_cond_eval
  import bbu_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic [CC_W-1:0]    cc_i,
  input  logic [SLOTS-1:0]   act_i,
  input  logic [2*SLOTS-1:0] slot_class_i,
  input  logic [4*SLOTS-1:0] slot_cond_i,
  output logic [SLOTS-1:0]   taken_o
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic is_br;
    assign is_br      = act_i[g] && (slot_class_i[2*g +: 2] == CLS_BRANCH);
    assign taken_o[g] = is_br && cond_holds(slot_cond_i[4*g +: 4], cc_i);
  end

endmodule

// File: rtl/bbu_pick_lowest.sv
module bbu_pick_lowest #(
  parameter int SLOTS = 8,
  parameter int PC_W  = 32
) (
  input  logic [SLOTS-1:0]      req_i,
  input  logic [PC_W*SLOTS-1:0] target_i,
  output logic                  any_o,
  output logic                  multi_o,
  output logic [PC_W-1:0]       sel_o
);

  always_comb begin
    sel_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = target_i[i*PC_W +: PC_W];
    end
  end

  assign any_o   = |req_i;
  // more than one bit set iff clearing the lowest leaves something
  assign multi_o = |(req_i & (req_i - SLOTS'(1)));

endmodule

// File: rtl/bbu_cc_merge.sv
module bbu_cc_merge
  import bbu_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic [SLOTS-1:0]   act_i,
  input  logic [2*SLOTS-1:0] slot_class_i,
  input  logic [SLOTS-1:0]   slot_setcc_i,
  input  logic [4*SLOTS-1:0] slot_flags_i,
  output logic               upd_o,
  output logic [CC_W-1:0]    flags_o
);

  logic [SLOTS-1:0] writes;

  for (genvar g = 0; g < SLOTS; g++) begin : g_wr
    // only ALU ops may write flags; memory and branch ops reuse the bit
    assign writes[g] = act_i[g] && slot_setcc_i[g] && (slot_class_i[2*g +: 2] == CLS_ALU);
  end

  always_comb begin
    flags_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (writes[i]) flags_o = slot_flags_i[4*i +: 4];
    end
  end

  assign upd_o = |writes;

endmodule

// File: rtl/block_branch_unit.sv
module block_branch_unit
  import bbu_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int PC_W       = 32,
  parameter int WORD_BYTES = 4,
  localparam int LEN_W     = $clog2(SLOTS + 1),
  localparam int WORD_SH   = $clog2(WORD_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  blk_valid_i,
  input  logic [PC_W-1:0]       blk_pc_i,
  input  logic [LEN_W-1:0]      blk_len_i,
  input  logic [2*SLOTS-1:0]    slot_class_i,
  input  logic [SLOTS-1:0]      slot_setcc_i,
  input  logic [4*SLOTS-1:0]    slot_cond_i,
  input  logic [PC_W*SLOTS-1:0] slot_target_i,
  input  logic [4*SLOTS-1:0]    slot_flags_i,
  output logic                  res_valid_o,
  output logic [PC_W-1:0]       next_pc_o,
  output logic                  taken_o,
  output logic                  multi_taken_o,
  output logic [CC_W-1:0]       cc_o
);

  logic [CC_W-1:0]  cc_q;
  logic             res_valid_q, taken_q, multi_q;
  logic [PC_W-1:0]  next_pc_q;

  logic [SLOTS-1:0] act;
  logic [SLOTS-1:0] br_taken;
  logic             any_taken, multi_taken;
  logic [PC_W-1:0]  br_target;
  logic             cc_upd;
  logic [CC_W-1:0]  cc_new;
  logic [PC_W-1:0]  fallthru;

  for (genvar g = 0; g < SLOTS; g++) begin : g_act
    assign act[g] = (LEN_W'(g) < blk_len_i);
  end

  assign fallthru = blk_pc_i + (PC_W'(blk_len_i) << WORD_SH);

  // branches see the flags as registered before this block
  bbu_cond_eval #(.SLOTS(SLOTS)) u_cond (
    .cc_i         (cc_q),
    .act_i        (act),
    .slot_class_i (slot_class_i),
    .slot_cond_i  (slot_cond_i),
    .taken_o      (br_taken)
  );

  bbu_pick_lowest #(.SLOTS(SLOTS), .PC_W(PC_W)) u_pick (
    .req_i    (br_taken),
    .target_i (slot_target_i),
    .any_o    (any_taken),
    .multi_o  (multi_taken),
    .sel_o    (br_target)
  );

  bbu_cc_merge #(.SLOTS(SLOTS)) u_cc (
    .act_i        (act),
    .slot_class_i (slot_class_i),
    .slot_setcc_i (slot_setcc_i),
    .slot_flags_i (slot_flags_i),
    .upd_o        (cc_upd),
    .flags_o      (cc_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q        <= '0;
      res_valid_q <= 1'b0;
      taken_q     <= 1'b0;
      multi_q     <= 1'b0;
      next_pc_q   <= '0;
    end else begin
      res_valid_q <= blk_valid_i;
      if (blk_valid_i) begin
        taken_q   <= any_taken;
        multi_q   <= multi_taken;
        next_pc_q <= any_taken ? br_target : fallthru;
        if (cc_upd) cc_q <= cc_new;
      end else begin
        taken_q <= 1'b0;
        multi_q <= 1'b0;
      end
    end
  end

  assign cc_o          = cc_q;
  assign res_valid_o   = res_valid_q;
  assign taken_o       = taken_q;
  assign multi_taken_o = multi_q;
  assign next_pc_o     = next_pc_q;

  p_res_follows_blk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(blk_valid_i));

  p_taken_needs_res_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> res_valid_o);

  p_no_setter_keeps_cc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && !cc_upd) |=> $stable(cc_o));

  p_multi_implies_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_taken_o |-> taken_o);

  p_idle_holds_cc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_valid_i |=> $stable(cc_o));

  p_not_taken_fallthru_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && !any_taken) |=> (!taken_o && next_pc_o == $past(fallthru)));

endmodule

// File: tb/sim_block_branch_unit.sv
module sim_block_branch_unit;

  localparam int SLOTS = 8;
  localparam int PC_W  = 32;
  localparam int LEN_W = $clog2(SLOTS + 1);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  blk_valid = 1'b0;
  logic [PC_W-1:0]       blk_pc = '0;
  logic [LEN_W-1:0]      blk_len = '0;
  logic [2*SLOTS-1:0]    s_class = '0;
  logic [SLOTS-1:0]      s_setcc = '0;
  logic [4*SLOTS-1:0]    s_cond = '0;
  logic [PC_W*SLOTS-1:0] s_target = '0;
  logic [4*SLOTS-1:0]    s_flags = '0;
  logic                  res_valid, taken, multi;
  logic [PC_W-1:0]       next_pc;
  logic [3:0]            cc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  block_branch_unit #(.SLOTS(SLOTS), .PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .blk_valid_i(blk_valid), .blk_pc_i(blk_pc),
    .blk_len_i(blk_len), .slot_class_i(s_class), .slot_setcc_i(s_setcc),
    .slot_cond_i(s_cond), .slot_target_i(s_target), .slot_flags_i(s_flags),
    .res_valid_o(res_valid), .next_pc_o(next_pc), .taken_o(taken),
    .multi_taken_o(multi), .cc_o(cc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit model_cond(input int sel, input int f);
    bit n, z, v, c, lt;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    lt = (n != v);
    case (sel)
      0: return 1;
      1: return z;
      2: return !z;
      3: return lt;
      4: return !lt;
      5: return !z && !lt;
      6: return z || lt;
      7: return c;
      8: return !c;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] tgt(input int i);
    return 32'h4000_0000 + 32'(i) * 32'h130;
  endfunction

  task automatic clear_slots();
    for (int i = 0; i < SLOTS; i++) begin
      s_class[2*i +: 2] = 2'd0;
      s_setcc[i] = 1'b0;
      s_cond[4*i +: 4] = 4'd15;
      s_target[PC_W*i +: PC_W] = tgt(i);
      s_flags[4*i +: 4] = 4'd0;
    end
  endtask

  task automatic set_slot(input int i, input int cls, input bit sc, input int sel, input int fl);
    s_class[2*i +: 2] = 2'(cls);
    s_setcc[i] = sc;
    s_cond[4*i +: 4] = 4'(sel);
    s_flags[4*i +: 4] = 4'(fl);
  endtask

  // present block at a negedge, sample one full cycle later
  task automatic issue(input logic [31:0] pc, input int len);
    @(negedge clk);
    blk_pc = pc;
    blk_len = LEN_W'(len);
    blk_valid = 1'b1;
    @(negedge clk);
    blk_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    clear_slots();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cc", 32'(cc), 0);
    chk("R1 res_valid", 32'(res_valid), 0);
    chk("R1 taken", 32'(taken), 0);
    chk("R1 multi", 32'(multi), 0);
    chk("R1 next_pc", next_pc, 0);
    rst_n = 1'b1;

    // R3/R4/R5/R7/R9: every flag value against every selector
    for (int f = 0; f < 16; f++) begin
      for (int sel = 0; sel < 16; sel++) begin
        int pos, sp;
        bit exp_t;
        logic [31:0] pc;
        clear_slots();
        set_slot(0, 0, 1, 0, f);
        pc = 32'h0001_0000 + 32'(f * 64);
        issue(pc, 1);
        chk("R5 cc load", 32'(cc), 32'(f));
        chk("R9 setter fallthru", next_pc, pc + 4);
        chk("R2 res_valid", 32'(res_valid), 1);

        clear_slots();
        pos = (sel + f) % SLOTS;
        sp  = (pos + 3) % SLOTS;
        set_slot(pos, 3, 0, sel, 0);
        set_slot(sp, 0, 1, 0, 15 - f);
        exp_t = model_cond(sel, f);
        pc = 32'h0002_0000 + 32'(sel * 256);
        issue(pc, SLOTS);
        chk("R4 R3 taken", 32'(taken), 32'(exp_t));
        chk(exp_t ? "R7 target" : "R9 fallthru", next_pc, exp_t ? tgt(pos) : pc + 32'(4 * SLOTS));
        chk("R4 cc after block", 32'(cc), 32'(15 - f));
      end
    end

    // R6: load, store and branch with set bit leave flags alone
    clear_slots();
    set_slot(0, 0, 1, 0, 4'h5);
    issue(32'h100, 1);
    clear_slots();
    set_slot(1, 1, 1, 0, 4'ha);
    set_slot(3, 2, 1, 0, 4'hc);
    set_slot(5, 3, 1, 9, 4'hf);
    issue(32'h200, 6);
    chk("R6 cc kept", 32'(cc), 32'h5);
    chk("R6 not taken", 32'(taken), 0);
    chk("R9 len6", next_pc, 32'h200 + 24);

    // R5: highest setter wins; R10: slot beyond length ignored
    clear_slots();
    set_slot(1, 0, 1, 0, 4'h1);
    set_slot(4, 0, 1, 0, 4'h2);
    set_slot(6, 0, 1, 0, 4'h9);
    set_slot(7, 0, 1, 0, 4'h6);
    issue(32'h300, 7);
    chk("R5 highest setter", 32'(cc), 32'h9);

    // R10: taken branch past length ignored
    clear_slots();
    set_slot(6, 3, 0, 0, 0);
    issue(32'h400, 5);
    chk("R10 taken", 32'(taken), 0);
    chk("R10 next_pc", next_pc, 32'h400 + 20);

    // R8: two taken branches
    clear_slots();
    set_slot(5, 3, 0, 0, 0);
    set_slot(2, 3, 0, 0, 0);
    issue(32'h500, 8);
    chk("R8 multi", 32'(multi), 1);
    chk("R8 lowest target", next_pc, tgt(2));
    chk("R8 taken", 32'(taken), 1);

    // R8: exclusive EQ/NE pair, cc = 0x9 has Z clear so NE (slot 5) taken
    clear_slots();
    set_slot(1, 3, 0, 1, 0);
    set_slot(5, 3, 0, 2, 0);
    issue(32'h600, 8);
    chk("R8 exclusive multi", 32'(multi), 0);
    chk("R8 exclusive target", next_pc, tgt(5));

    // R2/R11: idle cycles
    @(negedge clk);
    chk("R2 res_valid drops", 32'(res_valid), 0);
    chk("R2 taken drops", 32'(taken), 0);
    s_setcc = '1;
    s_flags = '1;
    repeat (4) @(negedge clk);
    chk("R11 cc held", 32'(cc), 32'h9);
    chk("R2 idle res_valid", 32'(res_valid), 0);

    // R9: empty block
    clear_slots();
    issue(32'h700, 0);
    chk("R9 empty block", next_pc, 32'h700);
    chk("R9 empty taken", 32'(taken), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule